// File: doc/BRIEF.md
# Shadow Memory Attribute Decoder

The block sits in a host bridge and classifies every host memory address in the legacy space between 640 KB and 1 MB. For each lookup it returns where the access should go: to system RAM, or forwarded to the PCI bus. Firmware programs per-segment attributes through a byte-wide configuration write port. Those attributes let option ROM and BIOS areas be copied into RAM and then write-protected.

Thirteen shadow segments are covered: twelve 16 KB blocks from 0xC0000 to 0xEFFFF and one 64 KB block at 0xF0000. Each has a 2-bit attribute packed two to a byte. A separate 128 KB system-management window at 0xA0000 is opened to RAM by a control byte together with the processor's system-management mode signal. When the window is closed, that range goes to PCI.

The lookup is combinational from the registered configuration. A memory controller can use the result in the same cycle as the address.

Top module: `shadow_attr_decoder`

## Requirements
- R1: After reset every shadow segment and the 0xA0000–0xBFFFF window route to PCI (route code 2), with `wr_block_o` low.
- R2: The 64 KB segment 0xF0000–0xFFFFF takes its attribute from bits [5:4] of the configuration byte at offset 0x59. The other bits of that byte have no effect on routing.
- R3: Segment i (0..11) covers 0xC0000 + i·0x4000 for 16 KB. Its attribute is bits [1:0] of the low nibble of byte 0x5A + (i>>1) when i is even, and bits [1:0] of the high nibble (bits [5:4]) when i is odd.
- R4: Attribute 3 routes to RAM. Attribute 1 routes to RAM read-only. Attributes 0 and 2 route to PCI. Route codes are 0 = not decoded, 1 = RAM, 2 = PCI.
- R5: A write (`lk_we_i`=1) to a segment with attribute 1 raises `wr_block_o` while the route stays RAM. A read never raises `wr_block_o`.
- R6: The window 0xA0000–0xBFFFF routes to RAM when (system-management mode is active and control bit 3 is set) or control bit 6 is set, and to PCI otherwise.
- R7: The system-management control byte is at offset 0x72 and resets to 0x02, so the window is closed after reset even with the mode input high.
- R8: Addresses below 0xA0000 or at or above 0x100000 (any bit above bit 19 set) return route 0 with `wr_block_o` low.
- R9: Configuration writes to offsets other than 0x59–0x5F and 0x72 change no routing result.
- R10: A configuration write or a change of `smm_i` affects lookups from the cycle after the clock edge that samples it, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration byte write strobe |
| cfg_addr_i | input | 8 | Configuration byte offset |
| cfg_wdata_i | input | 8 | Configuration write data |
| smm_i | input | 1 | System-management mode active |
| lk_addr_i | input | 32 | Lookup host address |
| lk_we_i | input | 1 | Lookup is a write |
| route_o | output | 2 | 0 not decoded, 1 RAM, 2 PCI |
| wr_block_o | output | 1 | Write to a read-only RAM segment |

## Verification
A corrupted attribute nibble is visible at `route_o` only when an address inside that one segment is presented. The bench therefore sweeps every segment after each register pattern, both with reads and with writes. A stale or wrongly sampled mode or control byte shows up in the 0xA0000 window within one cycle of the change. The bench samples both just before and just after the capturing edge, to catch effects that arrive a cycle early or a cycle late. A wrong byte-offset decode shows as a segment that reacts to a write it should ignore, or as one that fails to react to its own byte.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
  typedef enum logic [1:0] {
    ROUTE_NONE = 2'd0,
    ROUTE_RAM  = 2'd1,
    ROUTE_PCI  = 2'd2
  } route_e;

  localparam int unsigned ATTR_BASE  = 'h59;
  localparam int unsigned SMRAM_OFS  = 'h72;
  localparam logic [7:0]  SMRAM_RST  = 8'h02;
  localparam int unsigned SMRAM_GATE = 3;  // open only in system-management mode
  localparam int unsigned SMRAM_OPEN = 6;  // open unconditionally

  localparam logic [1:0] ATTR_RAM_RW = 2'b11;
  localparam logic [1:0] ATTR_RAM_RO = 2'b01;
endpackage

// File: rtl/attr_regfile.sv
module attr_regfile #(
  parameter int unsigned NUM_BYTES = 7,
  parameter int unsigned CFG_AW    = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cfg_we_i,
  input  logic [CFG_AW-1:0]      cfg_addr_i,
  input  logic [7:0]             cfg_wdata_i,
  output logic [NUM_BYTES*8-1:0] attr_o
);
  import shadow_pkg::*;

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
    localparam logic [CFG_AW-1:0] OFS = CFG_AW'(ATTR_BASE + g);
    logic [7:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          q <= 8'h00;
      else if (cfg_we_i && cfg_addr_i == OFS) q <= cfg_wdata_i;
    end
    assign attr_o[g*8 +: 8] = q;
  end
endmodule

// File: rtl/smram_ctl.sv
module smram_ctl #(
  parameter int unsigned CFG_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [7:0]        cfg_wdata_i,
  input  logic              smm_i,
  output logic              open_o
);
  import shadow_pkg::*;

  localparam logic [CFG_AW-1:0] OFS = CFG_AW'(SMRAM_OFS);

  logic [7:0] ctl_q;
  logic       smm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= SMRAM_RST;
      smm_q <= 1'b0;
    end else begin
      if (cfg_we_i && cfg_addr_i == OFS) ctl_q <= cfg_wdata_i;
      smm_q <= smm_i;
    end
  end

  assign open_o = (smm_q && ctl_q[SMRAM_GATE]) || ctl_q[SMRAM_OPEN];

  logic unused_ctl;
  assign unused_ctl = ^{ctl_q[7], ctl_q[5:4], ctl_q[2:0]};
endmodule

// File: rtl/seg_decode.sv
module seg_decode #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned NUM_SEG   = 12,
  parameter int unsigned NUM_BYTES = 7
) (
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic                   we_i,
  input  logic [NUM_BYTES*8-1:0] attr_i,
  input  logic                   smram_open_i,
  output logic [1:0]             route_o,
  output logic                   wr_block_o
);
  import shadow_pkg::*;

  localparam int unsigned SEG_W   = $clog2(NUM_SEG);
  localparam int unsigned SEG_LSB = 14;  // 16 KB granules
  localparam int unsigned LEG_W   = 20;  // legacy space is 1 MB

  logic             upper_zero, in_win, in_seg, in_top;
  logic [SEG_W-1:0] seg_idx;
  logic [1:0]       seg_attr [1<<SEG_W];
  logic [1:0]       sel_attr;
  route_e           route;

  assign upper_zero = ~|addr_i[ADDR_W-1:LEG_W];
  assign seg_idx    = addr_i[SEG_LSB +: SEG_W];
  assign in_win     = upper_zero && addr_i[19:17] == 3'b101;
  assign in_top     = upper_zero && addr_i[19:16] == 4'hF;
  assign in_seg     = upper_zero && addr_i[19:18] == 2'b11 && 32'(seg_idx) < NUM_SEG;

  // segment g: byte 1+g/2 of the attribute block, nibble g%2
  for (genvar g = 0; g < (1 << SEG_W); g++) begin : g_seg
    if (g < NUM_SEG) begin : g_on
      assign seg_attr[g] = attr_i[(1 + g/2)*8 + (g%2)*4 +: 2];
    end else begin : g_off
      assign seg_attr[g] = 2'b00;
    end
  end

  assign sel_attr = in_top ? attr_i[5:4] : seg_attr[seg_idx];

  always_comb begin
    route      = ROUTE_NONE;
    wr_block_o = 1'b0;
    if (in_win) begin
      route = smram_open_i ? ROUTE_RAM : ROUTE_PCI;
    end else if (in_top || in_seg) begin
      unique case (sel_attr)
        ATTR_RAM_RW: route = ROUTE_RAM;
        ATTR_RAM_RO: begin
          route      = ROUTE_RAM;
          wr_block_o = we_i;
        end
        default:     route = ROUTE_PCI;
      endcase
    end
  end

  assign route_o = route;

  logic unused_bits;
  assign unused_bits = ^{addr_i[SEG_LSB-1:0], attr_i};
endmodule

// File: rtl/shadow_attr_decoder.sv
module shadow_attr_decoder #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned CFG_AW  = 8,
  parameter int unsigned NUM_SEG = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [7:0]        cfg_wdata_i,
  input  logic              smm_i,
  input  logic [ADDR_W-1:0] lk_addr_i,
  input  logic              lk_we_i,
  output logic [1:0]        route_o,
  output logic              wr_block_o
);
  localparam int unsigned NUM_BYTES = 1 + (NUM_SEG + 1) / 2;

  logic [NUM_BYTES*8-1:0] attr;
  logic                   smram_open;

  attr_regfile #(.NUM_BYTES(NUM_BYTES), .CFG_AW(CFG_AW)) u_regs (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i,
    .attr_o(attr)
  );

  smram_ctl #(.CFG_AW(CFG_AW)) u_smram (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i, .smm_i,
    .open_o(smram_open)
  );

  seg_decode #(.ADDR_W(ADDR_W), .NUM_SEG(NUM_SEG), .NUM_BYTES(NUM_BYTES)) u_dec (
    .addr_i(lk_addr_i), .we_i(lk_we_i), .attr_i(attr),
    .smram_open_i(smram_open), .route_o, .wr_block_o
  );
endmodule

// File: rtl/shadow_attr_decoder_chk.sv
module shadow_attr_decoder_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CFG_AW = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic [CFG_AW-1:0] cfg_addr_i,
  input logic [7:0]        cfg_wdata_i,
  input logic              smm_i,
  input logic [ADDR_W-1:0] lk_addr_i,
  input logic              lk_we_i,
  input logic [1:0]        route_o,
  input logic              wr_block_o
);
  logic legacy, win, top;
  assign legacy = ~|lk_addr_i[ADDR_W-1:20] && lk_addr_i[19:17] >= 3'b101;
  assign win    = ~|lk_addr_i[ADDR_W-1:20] && lk_addr_i[19:17] == 3'b101;
  assign top    = ~|lk_addr_i[ADDR_W-1:20] && lk_addr_i[19:16] == 4'hF;

  // R8
  assert_outside_none_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !legacy |-> (route_o == 2'd0 && !wr_block_o));

  // R5
  assert_block_ram_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_block_o |-> (route_o == 2'd1 && lk_we_i));

  // R2
  assert_top_follows_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_addr_i == CFG_AW'('h59)) |=>
      (top |-> route_o == (($past(cfg_wdata_i[5:4]) == 2'b11 ||
                             $past(cfg_wdata_i[5:4]) == 2'b01) ? 2'd1 : 2'd2)));

  // R6
  assert_window_forced_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_addr_i == CFG_AW'('h72) && cfg_wdata_i[6]) |=>
      (win |-> route_o == 2'd1));

  // R6
  assert_window_gated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_addr_i == CFG_AW'('h72) && !cfg_wdata_i[6] && cfg_wdata_i[3]) |=>
      (win |-> route_o == ($past(smm_i) ? 2'd1 : 2'd2)));

  logic unused_chk;
  assign unused_chk = ^{cfg_wdata_i[7], cfg_wdata_i[2:0]};
endmodule

bind shadow_attr_decoder shadow_attr_decoder_chk #(.ADDR_W(ADDR_W), .CFG_AW(CFG_AW)) u_chk (.*);

// File: tb/tb_shadow_attr_decoder.sv
module tb_shadow_attr_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = 8'h00;
  logic [7:0]  cfg_wdata = 8'h00;
  logic        smm = 1'b0;
  logic [31:0] lk_addr = 32'h0;
  logic        lk_we = 1'b0;
  logic [1:0]  route;
  logic        wr_block;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] m_attr [7];
  logic [7:0] m_ctl;
  logic       m_smm;

  always #2 clk = ~clk;

  shadow_attr_decoder dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .smm_i(smm), .lk_addr_i(lk_addr), .lk_we_i(lk_we),
    .route_o(route), .wr_block_o(wr_block)
  );

  function automatic logic [1:0] attr_of(input logic [31:0] a);
    logic [3:0] i;
    logic [7:0] b;
    if (a[19:16] == 4'hF) return m_attr[0][5:4];
    i = a[17:14];
    b = m_attr[1 + i/2];
    return i[0] ? b[5:4] : b[1:0];
  endfunction

  function automatic logic [1:0] exp_route(input logic [31:0] a);
    logic [1:0] t;
    if (a[31:20] != 0 || a[19:17] < 3'b101) return 2'd0;
    if (a[19:17] == 3'b101) return ((m_smm && m_ctl[3]) || m_ctl[6]) ? 2'd1 : 2'd2;
    t = attr_of(a);
    return (t == 2'b11 || t == 2'b01) ? 2'd1 : 2'd2;
  endfunction

  function automatic logic exp_blk(input logic [31:0] a, input logic w);
    return exp_route(a) == 2'd1 && a[19:17] != 3'b101 && attr_of(a) == 2'b01 && w;
  endfunction

  task automatic check_lk(input logic [31:0] a, input logic w, input string req);
    lk_addr = a;
    lk_we   = w;
    #0.5;
    checks++;
    if (route !== exp_route(a) || wr_block !== exp_blk(a, w)) begin
      errors++;
      $display("FAIL %s addr=%h we=%0b route=%0d blk=%0b expected route=%0d blk=%0b",
               req, a, w, route, wr_block, exp_route(a), exp_blk(a, w));
    end
  endtask

  task automatic model_write(input logic [7:0] a, input logic [7:0] d);
    if (a >= 8'h59 && a <= 8'h5F) m_attr[a - 8'h59] = d;
    else if (a == 8'h72) m_ctl = d;
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    model_write(a, d);
  endtask

  task automatic set_smm(input logic v);
    @(negedge clk);
    smm = v;
    @(negedge clk);
    m_smm = v;
  endtask

  task automatic sweep(input string req);
    check_lk(32'h000A_0000, 1'b0, req);
    check_lk(32'h000B_FFFF, 1'b1, req);
    for (int i = 0; i < 12; i++) begin
      check_lk(32'h000C_0000 + i * 32'h4000, 1'b0, req);
      check_lk(32'h000C_3FFF + i * 32'h4000, 1'b1, req);
    end
    check_lk(32'h000F_0000, 1'b0, req);
    check_lk(32'h000F_FFFF, 1'b1, req);
  endtask

  task automatic t_reset;
    sweep("R1");
    set_smm(1'b1);
    check_lk(32'h000A_8000, 1'b0, "R7");
    set_smm(1'b0);
  endtask

  task automatic t_top_seg;
    cfg_write(8'h59, 8'h30);
    check_lk(32'h000F_1234, 1'b1, "R2");
    cfg_write(8'h59, 8'h10);
    check_lk(32'h000F_8000, 1'b0, "R2");
    check_lk(32'h000F_8000, 1'b1, "R5");
    cfg_write(8'h59, 8'hCF);
    check_lk(32'h000F_0000, 1'b1, "R2");
    cfg_write(8'h59, 8'h20);
    check_lk(32'h000F_0000, 1'b0, "R4");
  endtask

  task automatic t_segments;
    cfg_write(8'h5A, 8'h13);
    cfg_write(8'h5B, 8'h20);
    cfg_write(8'h5C, 8'h31);
    cfg_write(8'h5D, 8'h02);
    cfg_write(8'h5E, 8'h11);
    cfg_write(8'h5F, 8'h3C);
    sweep("R3");
    cfg_write(8'h5A, 8'h31);
    cfg_write(8'h5F, 8'h13);
    sweep("R4");
    cfg_write(8'h5C, 8'h11);
    sweep("R5");
  endtask

  task automatic t_smram;
    cfg_write(8'h72, 8'h08);
    check_lk(32'h000A_0000, 1'b0, "R6");
    set_smm(1'b1);
    check_lk(32'h000B_0000, 1'b1, "R6");
    cfg_write(8'h72, 8'hB7);
    check_lk(32'h000A_0000, 1'b0, "R6");
    cfg_write(8'h72, 8'h40);
    set_smm(1'b0);
    check_lk(32'h000A_4000, 1'b1, "R6");
    cfg_write(8'h72, 8'h00);
    check_lk(32'h000B_FFFF, 1'b0, "R6");
  endtask

  task automatic t_ignored;
    cfg_write(8'h58, 8'hFF);
    cfg_write(8'h60, 8'hFF);
    cfg_write(8'h71, 8'hFF);
    cfg_write(8'h73, 8'hFF);
    cfg_write(8'hD9, 8'hFF);
    sweep("R9");
  endtask

  task automatic t_outside;
    check_lk(32'h0009_FFFF, 1'b0, "R8");
    check_lk(32'h0000_0000, 1'b1, "R8");
    check_lk(32'h0010_0000, 1'b0, "R8");
    check_lk(32'h001F_0000, 1'b1, "R8");
    check_lk(32'hFFFF_FFFF, 1'b1, "R8");
    check_lk(32'h800C_0000, 1'b1, "R8");
  endtask

  task automatic t_timing;
    cfg_write(8'h5A, 8'h00);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 8'h5A; cfg_wdata = 8'h03;
    check_lk(32'h000C_0000, 1'b0, "R10");
    @(posedge clk);
    #0.5;
    model_write(8'h5A, 8'h03);
    check_lk(32'h000C_0000, 1'b0, "R10");
    @(negedge clk);
    cfg_we = 1'b0;
    cfg_write(8'h72, 8'h08);
    @(negedge clk);
    smm = 1'b1;
    check_lk(32'h000A_0000, 1'b0, "R10");
    @(posedge clk);
    #0.5;
    m_smm = 1'b1;
    check_lk(32'h000A_0000, 1'b0, "R10");
  endtask

  initial begin
    for (int i = 0; i < 7; i++) m_attr[i] = 8'h00;
    m_ctl = 8'h02;
    m_smm = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_top_seg();
    t_segments();
    t_smram();
    t_ignored();
    t_outside();
    t_timing();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired: actual hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule